// File: doc/BRIEF.md
# Byte-Wide Memory Port with Two-Cycle Access

This unit sits between an 8-bit processor datapath and a main memory that is one byte wide and addressed with 16 bits. It holds the memory address register and the memory data register. It turns the datapath's read and write requests into memory strobes, and it drives the bidirectional data bus during writes.

The address register is loaded in a single strobe: one byte from the A bus and one byte from the B bus. The data register is loaded on its own strobe from one of two sources. A select line picks either the memory data bus or the internal C bus.

Every access needs its request to stay high for two consecutive cycles. The memory strobe appears only in the second of those cycles. A request held for one cycle only is dropped without any effect. A read and a write requested together count as an error, and no access takes place.

Top module: `mem_port_unit`

## Requirements
- R1: While rst_ni is low, the address output and the data register output are 0, both memory strobes are 0, and the error flag is 0.
- R2: At a clock edge with mar_ld_i high, mem_addr_o becomes {a_bus_i, b_bus_i}, with a_bus_i in bits 15:8 and b_bus_i in bits 7:0. With mar_ld_i low, mem_addr_o keeps its value.
- R3: At a clock edge with mdr_ld_i high and mdr_sel_i = 1, mdr_o takes c_bus_i. With mdr_ld_i low, mdr_o keeps its value.
- R4: A read request (rd_i high, wr_i low) in two consecutive cycles raises mem_rd_o in the second cycle only. mem_rd_o stays low in the first cycle.
- R5: In the second read cycle the memory drives mem_data_io. If mdr_ld_i is high and mdr_sel_i = 0 in that cycle, mdr_o holds that byte after the edge.
- R6: A write request (wr_i high, rd_i low) in two consecutive cycles raises mem_wr_o in the second cycle only. The memory byte at mem_addr_o then takes mdr_o at the end of that cycle.
- R7: The unit drives mem_data_io with mdr_o only while mem_wr_o is high. At all other times it releases the bus, so that data read from memory reaches the data register unchanged.
- R8: A request that is not followed in the next cycle by the same kind of request is abandoned. This covers a request that is dropped and a request that changes from read to write. No strobe is raised and memory is unchanged.
- R9: rd_i and wr_i high together raise err_o in that cycle. Neither strobe is raised, and any half-done access is cancelled, so the next single-direction request counts as a first cycle.
- R10: A completing cycle starts nothing. A request held for four cycles gives the strobe pattern 0,1,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_bus_i | input | 8 | A bus byte, high address byte |
| b_bus_i | input | 8 | B bus byte, low address byte |
| c_bus_i | input | 8 | C bus byte, internal source for the data register |
| mar_ld_i | input | 1 | Address register load strobe |
| mdr_ld_i | input | 1 | Data register load strobe |
| mdr_sel_i | input | 1 | Data register source: 0 memory bus, 1 C bus |
| rd_i | input | 1 | Read request from control |
| wr_i | input | 1 | Write request from control |
| mem_addr_o | output | 16 | Memory address |
| mem_data_io | inout | 8 | Bidirectional memory data bus |
| mem_rd_o | output | 1 | Read strobe, high in the completing cycle |
| mem_wr_o | output | 1 | Write strobe, high in the completing cycle |
| mdr_o | output | 8 | Data register contents |
| err_o | output | 1 | Read and write requested together |

## Verification
A data register load and the completing cycle of a read can fall in the same cycle. Capturing read data depends on exactly that: the bench asserts mdr_ld_i with the memory source selected in the cycle where mem_rd_o rises, and judges it by comparing mdr_o after the edge with the byte the memory model holds. The data register is first loaded with a different value, so a driver conflict or a miss would show up. A completing access can also meet a held request that would start a new one. The bench holds a request for four cycles and checks the strobe pattern cycle by cycle.

// File: rtl/mem_port_pkg.sv
package mem_port_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } mem_op_e;
endpackage

// File: rtl/mpu_addr_reg.sv
module mpu_addr_reg #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_o <= '0;
    else if (ld_i) addr_o <= {hi_i, lo_i};
  end
endmodule

// File: rtl/mpu_data_reg.sv
module mpu_data_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] int_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] src;

  // sel 0: memory bus, sel 1: internal C bus
  always_comb src = sel_i ? int_i : bus_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (ld_i) data_o <= src;
  end
endmodule

// File: rtl/mpu_access_seq.sv
module mpu_access_seq
  import mem_port_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  output logic rd_fire_o,
  output logic wr_fire_o,
  output logic err_o
);
  mem_op_e op_now, op_q;
  logic    armed_q, fire;

  always_comb begin
    unique case ({wr_i, rd_i})
      2'b01:   op_now = OP_RD;
      2'b10:   op_now = OP_WR;
      default: op_now = OP_NONE;
    endcase
  end

  // second consecutive cycle of the same request completes the access
  assign fire      = armed_q && (op_now != OP_NONE) && (op_now == op_q);
  assign rd_fire_o = fire && (op_now == OP_RD);
  assign wr_fire_o = fire && (op_now == OP_WR);
  assign err_o     = rd_i && wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      op_q    <= OP_NONE;
    end else if (fire || op_now == OP_NONE) begin
      armed_q <= 1'b0;
      op_q    <= OP_NONE;
    end else begin
      armed_q <= 1'b1;
      op_q    <= op_now;
    end
  end
endmodule

// File: rtl/mem_port_unit.sv
module mem_port_unit #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_bus_i,
  input  logic [DATA_W-1:0] b_bus_i,
  input  logic [DATA_W-1:0] c_bus_i,
  input  logic              mar_ld_i,
  input  logic              mdr_ld_i,
  input  logic              mdr_sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  inout  wire  [DATA_W-1:0] mem_data_io,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic              err_o
);
  mpu_addr_reg #(.DATA_W(DATA_W)) u_mar (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (mar_ld_i),
    .hi_i  (a_bus_i),
    .lo_i  (b_bus_i),
    .addr_o(mem_addr_o)
  );

  mpu_data_reg #(.DATA_W(DATA_W)) u_mdr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (mdr_ld_i),
    .sel_i (mdr_sel_i),
    .bus_i (mem_data_io),
    .int_i (c_bus_i),
    .data_o(mdr_o)
  );

  mpu_access_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .rd_fire_o(mem_rd_o),
    .wr_fire_o(mem_wr_o),
    .err_o    (err_o)
  );

  assign mem_data_io = mem_wr_o ? mdr_o : {DATA_W{1'bz}};
endmodule

// File: rtl/mem_port_unit_chk.sv
module mem_port_unit_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_bus_i,
  input logic [DATA_W-1:0] b_bus_i,
  input logic [DATA_W-1:0] c_bus_i,
  input logic              mar_ld_i,
  input logic              mdr_ld_i,
  input logic              mdr_sel_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_io,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [DATA_W-1:0] mdr_o,
  input logic              err_o
);
  p_mar_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mar_ld_i |=> mem_addr_o == $past({a_bus_i, b_bus_i}));

  p_mar_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mar_ld_i |=> $stable(mem_addr_o));

  p_mdr_from_c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdr_ld_i && mdr_sel_i) |=> mdr_o == $past(c_bus_i));

  p_mdr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mdr_ld_i |=> $stable(mdr_o));

  p_rd_two_cycles_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (rd_i && !wr_i && $past(rd_i) && !$past(wr_i)));

  p_wr_two_cycles_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (wr_i && !rd_i && $past(wr_i) && !$past(rd_i)));

  p_wr_drives_mdr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> mem_data_io == mdr_o);

  p_illegal_no_access_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!mem_rd_o && !mem_wr_o));

  p_rd_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_wr_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);
endmodule

bind mem_port_unit mem_port_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mem_port_unit_tb_top.sv
`timescale 1ns/1ps
module mem_port_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a_bus = '0, b_bus = '0, c_bus = '0;
  logic        mar_ld = 0, mdr_ld = 0, mdr_sel = 0, rd = 0, wr = 0;
  logic [15:0] addr;
  wire  [7:0]  data_bus;
  logic        mem_rd, mem_wr, mdr_err;
  logic [7:0]  mdr;
  logic [7:0]  mem [256];

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mem_port_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_bus_i(a_bus), .b_bus_i(b_bus), .c_bus_i(c_bus),
    .mar_ld_i(mar_ld), .mdr_ld_i(mdr_ld), .mdr_sel_i(mdr_sel), .rd_i(rd), .wr_i(wr),
    .mem_addr_o(addr), .mem_data_io(data_bus), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mdr_o(mdr), .err_o(mdr_err)
  );

  // memory model: byte i resets to i ^ 8'h5A
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (mem_wr) mem[addr[7:0]] <= data_bus;
  end
  assign data_bus = mem_rd ? mem[addr[7:0]] : 8'bz;

  typedef struct packed {
    logic        mar_ld;
    logic        mdr_ld;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  c;
    logic [15:0] exp_addr;
    logic [7:0]  exp_mdr;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 8'h12, 8'h34, 8'h99, 16'h1234, 8'h00},
    '{1'b0, 1'b1, 8'hFF, 8'hFF, 8'h5C, 16'h1234, 8'h5C},
    '{1'b1, 1'b1, 8'hAB, 8'hCD, 8'hE1, 16'hABCD, 8'hE1},
    '{1'b0, 1'b0, 8'h00, 8'h00, 8'h77, 16'hABCD, 8'hE1},
    '{1'b1, 1'b0, 8'h00, 8'hFF, 8'h00, 16'h00FF, 8'hE1},
    '{1'b1, 1'b1, 8'h80, 8'h01, 8'h00, 16'h8001, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // drive at negedge, look at combinational outputs 1 ns later
  task automatic cyc(input logic r, input logic w);
    @(negedge clk);
    rd = r; wr = w;
    #1;
  endtask

  task automatic load_mar(input logic [15:0] a);
    @(negedge clk);
    {a_bus, b_bus} = a; mar_ld = 1;
    @(negedge clk);
    mar_ld = 0;
  endtask

  task automatic load_mdr_c(input logic [7:0] v);
    @(negedge clk);
    c_bus = v; mdr_sel = 1; mdr_ld = 1;
    @(negedge clk);
    mdr_ld = 0;
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    #3;
    chk("R1 addr", addr, 16'h0);
    chk("R1 mdr", {8'h0, mdr}, 16'h0);
    chk("R1 strobes/err", {13'h0, mem_rd, mem_wr, mdr_err}, 16'h0);
    @(negedge clk); rst_n = 1;

    // table walk: R2 address load / hold, R3 C-bus load / hold
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      mar_ld = VEC[i].mar_ld; mdr_ld = VEC[i].mdr_ld; mdr_sel = 1;
      a_bus = VEC[i].a; b_bus = VEC[i].b; c_bus = VEC[i].c;
      @(negedge clk);
      mar_ld = 0; mdr_ld = 0;
      chk("R2 mar", addr, VEC[i].exp_addr);
      chk("R3 mdr", {8'h0, mdr}, {8'h0, VEC[i].exp_mdr});
    end

    // R6/R7 write
    load_mar(16'h0010);
    load_mdr_c(8'hA7);
    cyc(0, 1);
    chk("R6 first cycle no strobe", {15'h0, mem_wr}, 16'h0);
    cyc(0, 1);
    chk("R6 second cycle strobe", {15'h0, mem_wr}, 16'h1);
    chk("R7 bus driven with mdr", {8'h0, data_bus}, 16'h00A7);
    cyc(0, 0);
    chk("R6 memory written", {8'h0, mem[8'h10]}, 16'h00A7);

    // R4/R5 read, MDR preloaded with other value
    load_mar(16'h0020);
    load_mdr_c(8'hC3);
    cyc(1, 0);
    chk("R4 first cycle no strobe", {15'h0, mem_rd}, 16'h0);
    cyc(1, 0);
    mdr_sel = 0; mdr_ld = 1;
    chk("R4 second cycle strobe", {15'h0, mem_rd}, 16'h1);
    cyc(0, 0);
    mdr_ld = 0;
    chk("R5 read capture", {8'h0, mdr}, 16'h007A);

    // R8 abandoned write
    load_mar(16'h0030);
    load_mdr_c(8'h11);
    cyc(0, 1); chk("R8 no strobe a", {14'h0, mem_rd, mem_wr}, 16'h0);
    cyc(0, 0);
    cyc(0, 1); chk("R8 no strobe b", {14'h0, mem_rd, mem_wr}, 16'h0);
    cyc(1, 0); chk("R8 rd after wr no strobe", {14'h0, mem_rd, mem_wr}, 16'h0);
    cyc(0, 0);
    chk("R8 memory unchanged", {8'h0, mem[8'h30]}, 16'h006A);

    // R9 illegal cancels half access
    cyc(0, 1);
    cyc(1, 1);
    chk("R9 err", {15'h0, mdr_err}, 16'h1);
    chk("R9 no strobe", {14'h0, mem_rd, mem_wr}, 16'h0);
    cyc(0, 1);
    chk("R9 restart is first cycle", {14'h0, mem_rd, mem_wr}, 16'h0);
    chk("R9 err clear", {15'h0, mdr_err}, 16'h0);
    cyc(0, 1);
    chk("R9 then completes", {15'h0, mem_wr}, 16'h1);
    cyc(0, 0);
    chk("R9 memory written", {8'h0, mem[8'h30]}, 16'h0011);

    // R10 held read: 0,1,0,1
    begin
      logic [3:0] pat;
      for (int k = 0; k < 4; k++) begin
        cyc(1, 0);
        pat[k] = mem_rd;
      end
      cyc(0, 0);
      chk("R10 strobe pattern", {12'h0, pat}, 16'h000A);
    end

    summary();
  end
endmodule